// File: doc/BRIEF.md
# Dual-Clear Watchdog Timer with Halt Status Flags

This block supervises a processor core. An eight-bit watchdog counter advances once per prescaler tick. When it passes its top value it raises a one-cycle reset request and latches a time-out status flag. Software keeps it quiet by issuing clear commands. A configuration bit selects how that works. In single mode, one clear strobe is enough. In dual mode, two different clear strobes must arrive in alternation, so a runaway loop that keeps repeating one clear command cannot hold off the reset.

The block also owns the power-down status flag and the halt/wake sequencing. A halt strobe resets the watchdog and its prescaler, sets the power-down flag and stops the core. A later wake strobe starts a fixed delay. The core's run enable rises only when that delay has elapsed. While the core is not running, clear and halt strobes are ignored. The watchdog keeps counting through halt.

Top module: `dual_clear_watchdog`

## Requirements
- R1: After a synchronous reset, to_flag_o=0, pd_flag_o=0, reset_req_o=0 and run_o=1.
- R2: The prescaler advances every cycle. A watchdog tick occurs in each cycle whose prescaler value has its low ps_sel_i bits all ones, so there is one tick every 2^ps_sel_i cycles. With no clear, 256 ticks after a wipe the counter expires.
- R3: With dual_clear_i=0, a clr_single_i pulse while running wipes the counter and prescaler and clears both flags. clr_a_i and clr_b_i have no effect in this mode.
- R4: With dual_clear_i=1, a wipe needs clr_a_i and clr_b_i in alternation, in either order. clr_single_i has no effect in this mode.
- R5: In dual mode, repeating the same clear strobe without the other one in between has no effect.
- R6: A completed pair forgets its history, so the next pair may begin with either strobe. Both strobes in one cycle count as a complete pair.
- R7: A halt strobe while running wipes the counter and prescaler, sets pd_flag_o, clears to_flag_o and drops run_o on the next cycle.
- R8: After a wake strobe during halt, run_o rises exactly 1024 cycles after the edge that sampled the wake. Clear and halt strobes are ignored while run_o is low.
- R9: On expiry, in any state, to_flag_o is set and reset_req_o is high for exactly one cycle. The counter wraps to zero. A simultaneous clear or halt takes precedence over the expiry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high power-up reset |
| dual_clear_i | input | 1 | 1 = two-strobe clear mode, 0 = single-strobe |
| ps_sel_i | input | 3 | Prescaler select, tick every 2^ps_sel_i cycles |
| clr_single_i | input | 1 | Single clear strobe |
| clr_a_i | input | 1 | First-kind clear strobe for dual mode |
| clr_b_i | input | 1 | Second-kind clear strobe for dual mode |
| halt_i | input | 1 | Halt strobe |
| wake_i | input | 1 | Wake strobe |
| to_flag_o | output | 1 | Time-out status flag |
| pd_flag_o | output | 1 | Power-down status flag |
| reset_req_o | output | 1 | One-cycle reset request on expiry |
| run_o | output | 1 | Core run enable |

## Verification
Clearing is tried with single strobes at short intervals, which must suppress every expiry, and with the two dual-mode strobes used in the wrong mode, which must still let it expire. Dual mode is tried with:
- A-then-B pairs and B-then-A pairs, which tell order independence apart from a fixed order.
- Only A strobes, which tell pending-state tracking apart from a plain edge count.
- Both strobes in one cycle.
- A lone B after a finished pair, which shows the history was flushed.

Halt is tried with a slow prescaler and then with a fast one, so that an expiry during halt is seen to set the time-out flag without touching the power-down flag. A halt strobe inside the wake delay shows that the 1024-cycle count is not restarted.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  typedef enum logic [1:0] {
    PWR_RUN  = 2'd0,
    PWR_HALT = 2'd1,
    PWR_WAKE = 2'd2
  } pwr_state_t;

  typedef enum logic [1:0] {
    SEQ_NONE  = 2'd0,
    SEQ_GOT_A = 2'd1,
    SEQ_GOT_B = 2'd2
  } clr_pend_t;

endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o
);
  localparam int PS_W = (1 << SEL_W) - 1;

  logic [PS_W-1:0] cnt_q;
  logic [PS_W-1:0] mask;

  // one mask bit per prescaler stage: stage gi is used when sel exceeds gi
  for (genvar gi = 0; gi < PS_W; gi++) begin : g_mask
    assign mask[gi] = (32'(sel_i) > gi);
  end

  assign tick_o = ((cnt_q & mask) == mask);

  always_ff @(posedge clk) begin
    if (rst || clr_i) cnt_q <= '0;
    else              cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/wdt_clear_seq.sv
module wdt_clear_seq
  import wdt_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic en_i,
  input  logic dual_i,
  input  logic flush_i,
  input  logic single_i,
  input  logic a_i,
  input  logic b_i,
  output logic ok_o
);
  clr_pend_t pend_q;

  always_comb begin
    ok_o = 1'b0;
    if (en_i) begin
      if (!dual_i) ok_o = single_i;
      else         ok_o = (a_i && b_i) ||
                          (a_i && pend_q == SEQ_GOT_B) ||
                          (b_i && pend_q == SEQ_GOT_A);
    end
  end

  always_ff @(posedge clk) begin
    if (rst || flush_i || !dual_i) begin
      pend_q <= SEQ_NONE;
    end else if (en_i) begin
      if (ok_o)     pend_q <= SEQ_NONE;
      else if (a_i) pend_q <= SEQ_GOT_A;
      else if (b_i) pend_q <= SEQ_GOT_B;
    end
  end
endmodule

// File: rtl/wdt_wake_ctrl.sv
module wdt_wake_ctrl
  import wdt_pkg::*;
#(
  parameter int WAKE_CYC = 1024
) (
  input  logic clk,
  input  logic rst,
  input  logic halt_i,
  input  logic wake_i,
  output logic run_o
);
  localparam int CW = (WAKE_CYC > 1) ? $clog2(WAKE_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(WAKE_CYC - 1);

  pwr_state_t    st_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= PWR_RUN;
      cnt_q <= '0;
    end else begin
      case (st_q)
        PWR_RUN:  if (halt_i) st_q <= PWR_HALT;
        PWR_HALT: if (wake_i) begin
                    st_q  <= PWR_WAKE;
                    cnt_q <= '0;
                  end
        PWR_WAKE: if (cnt_q == LAST) st_q <= PWR_RUN;
                  else               cnt_q <= cnt_q + 1'b1;
        default:  st_q <= PWR_RUN;
      endcase
    end
  end

  assign run_o = (st_q == PWR_RUN);
endmodule

// File: rtl/dual_clear_watchdog.sv
module dual_clear_watchdog #(
  parameter int SEL_W    = 3,
  parameter int WD_W     = 8,
  parameter int WAKE_CYC = 1024
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             dual_clear_i,
  input  logic [SEL_W-1:0] ps_sel_i,
  input  logic             clr_single_i,
  input  logic             clr_a_i,
  input  logic             clr_b_i,
  input  logic             halt_i,
  input  logic             wake_i,
  output logic             to_flag_o,
  output logic             pd_flag_o,
  output logic             reset_req_o,
  output logic             run_o
);
  logic            tick;
  logic            clr_ok;
  logic            halt_acc;
  logic            wipe;
  logic            expire;
  logic [WD_W-1:0] wd_q;
  logic            to_q, pd_q, req_q;

  assign halt_acc = halt_i && run_o;
  assign wipe     = halt_acc || clr_ok;
  assign expire   = tick && (wd_q == '1) && !wipe;

  wdt_prescaler #(.SEL_W(SEL_W)) u_ps (
    .clk(clk), .rst(rst), .clr_i(wipe), .sel_i(ps_sel_i), .tick_o(tick)
  );

  wdt_clear_seq u_seq (
    .clk(clk), .rst(rst), .en_i(run_o), .dual_i(dual_clear_i),
    .flush_i(halt_acc), .single_i(clr_single_i), .a_i(clr_a_i),
    .b_i(clr_b_i), .ok_o(clr_ok)
  );

  wdt_wake_ctrl #(.WAKE_CYC(WAKE_CYC)) u_wake (
    .clk(clk), .rst(rst), .halt_i(halt_acc), .wake_i(wake_i), .run_o(run_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      wd_q  <= '0;
      to_q  <= 1'b0;
      pd_q  <= 1'b0;
      req_q <= 1'b0;
    end else begin
      if (wipe)      wd_q <= '0;
      else if (tick) wd_q <= wd_q + 1'b1;
      req_q <= expire;
      if (halt_acc) begin
        to_q <= 1'b0;
        pd_q <= 1'b1;
      end else if (clr_ok) begin
        to_q <= 1'b0;
        pd_q <= 1'b0;
      end else if (expire) begin
        to_q <= 1'b1;
      end
    end
  end

  assign to_flag_o   = to_q;
  assign pd_flag_o   = pd_q;
  assign reset_req_o = req_q;
endmodule

// File: rtl/dual_clear_watchdog_chk.sv
module dual_clear_watchdog_chk (
  input logic clk,
  input logic rst,
  input logic dual_clear_i,
  input logic clr_single_i,
  input logic halt_i,
  input logic to_flag_o,
  input logic pd_flag_o,
  input logic reset_req_o,
  input logic run_o
);
  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (!to_flag_o && !pd_flag_o && !reset_req_o && run_o));

  // R9
  req_single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    reset_req_o |=> !reset_req_o);

  // R9
  req_sets_to_chk: assert property (@(posedge clk) disable iff (rst)
    reset_req_o |-> to_flag_o);

  // R7
  halt_flags_chk: assert property (@(posedge clk) disable iff (rst)
    (halt_i && run_o) |=> (pd_flag_o && !to_flag_o && !run_o));

  // R7
  pd_source_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(pd_flag_o) |-> $past(halt_i && run_o));

  // R3
  single_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (!dual_clear_i && clr_single_i && run_o && !halt_i) |=>
      (!to_flag_o && !pd_flag_o && !reset_req_o));
endmodule

bind dual_clear_watchdog dual_clear_watchdog_chk u_chk (
  .clk(clk), .rst(rst), .dual_clear_i(dual_clear_i),
  .clr_single_i(clr_single_i), .halt_i(halt_i), .to_flag_o(to_flag_o),
  .pd_flag_o(pd_flag_o), .reset_req_o(reset_req_o), .run_o(run_o)
);

// File: tb/dual_clear_watchdog_tb.sv
`timescale 1ns/1ps
module dual_clear_watchdog_tb;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       rst = 1'b1, dual = 1'b0, cs = 1'b0, ca = 1'b0, cb = 1'b0;
  logic       hl = 1'b0, wk = 1'b0;
  logic [2:0] sel = 3'd0;
  logic       to_o, pd_o, req_o, run_o;

  dual_clear_watchdog u_dut (
    .clk(clk), .rst(rst), .dual_clear_i(dual), .ps_sel_i(sel),
    .clr_single_i(cs), .clr_a_i(ca), .clr_b_i(cb), .halt_i(hl),
    .wake_i(wk), .to_flag_o(to_o), .pd_flag_o(pd_o),
    .reset_req_o(req_o), .run_o(run_o)
  );

  int    n_chk = 0, n_fail = 0, req_cnt = 0;
  bit    cmp_en = 1'b0;
  string cur_req = "R1";

  // behavioural reference: integers, states 0 run / 1 halt / 2 wake, pend 0/1(a)/2(b)
  int m_p = 0, m_wd = 0, m_to = 0, m_pd = 0, m_req = 0, m_st = 0, m_wc = 0, m_pend = 0;
  int period, hacc, ok, tk, tout;

  always @(posedge clk) begin
    if (rst) begin
      m_p = 0; m_wd = 0; m_to = 0; m_pd = 0; m_req = 0; m_st = 0; m_wc = 0; m_pend = 0;
    end else begin
      period = 1 << int'(sel);
      hacc = (hl && m_st == 0) ? 1 : 0;
      ok = 0;
      if (m_st == 0) begin
        if (!dual) ok = cs ? 1 : 0;
        else ok = ((ca && cb) || (ca && m_pend == 2) || (cb && m_pend == 1)) ? 1 : 0;
      end
      tk = ((m_p % period) == period - 1) ? 1 : 0;
      tout = (tk == 1 && m_wd == 255 && hacc == 0 && ok == 0) ? 1 : 0;
      if (!dual || hacc == 1) m_pend = 0;
      else if (m_st == 0) begin
        if (ok == 1) m_pend = 0;
        else if (ca) m_pend = 1;
        else if (cb) m_pend = 2;
      end
      if (hacc == 1 || ok == 1) begin m_wd = 0; m_p = 0; end
      else begin
        if (tk == 1) m_wd = (m_wd + 1) % 256;
        m_p = (m_p + 1) % 128;
      end
      m_req = tout;
      if (hacc == 1) begin m_to = 0; m_pd = 1; end
      else if (ok == 1) begin m_to = 0; m_pd = 0; end
      else if (tout == 1) m_to = 1;
      if (m_st == 0) begin if (hacc == 1) m_st = 1; end
      else if (m_st == 1) begin if (wk) begin m_st = 2; m_wc = 0; end end
      else begin
        if (m_wc == 1023) m_st = 0;
        else m_wc = m_wc + 1;
      end
    end
  end

  always @(negedge clk) begin
    if (cmp_en) begin
      req_cnt += int'(req_o);
      n_chk++;
      if ({to_o, pd_o, req_o, run_o} !== {m_to[0], m_pd[0], m_req[0], m_st == 0}) begin
        n_fail++;
        $display("FAIL %s: to/pd/req/run got %b%b%b%b expected %b%b%b%b", cur_req,
                 to_o, pd_o, req_o, run_o, m_to[0], m_pd[0], m_req[0], m_st == 0);
      end
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input logic s, input logic a, input logic b,
                       input logic h, input logic w);
    @(negedge clk);
    cs = s; ca = a; cb = b; hl = h; wk = w;
    @(negedge clk);
    cs = 1'b0; ca = 1'b0; cb = 1'b0; hl = 1'b0; wk = 1'b0;
  endtask

  task automatic expect_eq(input int got, input int exp, input string tag);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog (all requirements): got hang expected finish");
    finish_run();
  end

  int rc0;

  initial begin
    step(3);
    rst = 1'b0;
    cmp_en = 1'b1;
    step(1);
    // R1 reset state
    cur_req = "R1";
    expect_eq({to_o, pd_o, req_o, run_o}, 4'b0001, "R1 reset outputs");

    // R2 / R9: fastest prescaler expires after 256 cycles
    cur_req = "R2";
    rc0 = req_cnt;
    step(300);
    expect_eq(req_cnt - rc0, 1, "R2 one expiry in 300 cycles at sel 0");
    expect_eq(int'(to_o), 1, "R9 time-out flag set");

    // R3 single mode clears keep it quiet
    cur_req = "R3";
    sel = 3'd2;
    pulse(1, 0, 0, 0, 0);
    expect_eq(int'(to_o), 0, "R3 single clear drops time-out flag");
    rc0 = req_cnt;
    for (int i = 0; i < 10; i++) begin step(200); pulse(1, 0, 0, 0, 0); end
    expect_eq(req_cnt - rc0, 0, "R3 regular single clears prevent expiry");
    // R3 dual strobes ignored in single mode
    rc0 = req_cnt;
    for (int i = 0; i < 6; i++) begin step(100); pulse(0, 1, 0, 0, 0); step(100); pulse(0, 0, 1, 0, 0); end
    expect_eq(req_cnt - rc0, 1, "R3 a/b strobes ignored in single mode");

    // R4 dual mode, A then B pairs
    cur_req = "R4";
    dual = 1'b1;
    pulse(0, 1, 0, 0, 0); pulse(0, 0, 1, 0, 0);
    expect_eq(int'(to_o), 0, "R4 pair clears time-out flag");
    rc0 = req_cnt;
    for (int i = 0; i < 8; i++) begin step(50); pulse(0, 1, 0, 0, 0); step(100); pulse(0, 0, 1, 0, 0); end
    // R4 B then A pairs
    for (int i = 0; i < 8; i++) begin step(50); pulse(0, 0, 1, 0, 0); step(100); pulse(0, 1, 0, 0, 0); end
    expect_eq(req_cnt - rc0, 0, "R4 alternating pairs prevent expiry");
    // R4 single strobe ignored in dual mode
    pulse(0, 1, 0, 0, 0); pulse(0, 0, 1, 0, 0);
    rc0 = req_cnt;
    for (int i = 0; i < 13; i++) begin step(100); pulse(1, 0, 0, 0, 0); end
    expect_eq(req_cnt - rc0, 1, "R4 single strobe ignored in dual mode");

    // R5 repeated A never clears
    cur_req = "R5";
    pulse(0, 1, 0, 0, 0); pulse(0, 0, 1, 0, 0);
    rc0 = req_cnt;
    for (int i = 0; i < 13; i++) begin step(100); pulse(0, 1, 0, 0, 0); end
    expect_eq(req_cnt - rc0, 1, "R5 repeated same strobe has no effect");

    // R6 history flushed after a pair; both-in-one-cycle counts as a pair
    cur_req = "R6";
    pulse(0, 1, 0, 0, 0); pulse(0, 0, 1, 0, 0);
    rc0 = req_cnt;
    for (int i = 0; i < 6; i++) begin
      step(100); pulse(0, 0, 1, 0, 0); step(50); pulse(0, 1, 0, 0, 0);
      step(100); pulse(0, 1, 1, 0, 0);
    end
    expect_eq(req_cnt - rc0, 0, "R6 flushed history and same-cycle pairs clear");

    // R7 halt with slow prescaler
    cur_req = "R7";
    sel = 3'd7;
    step(20);
    pulse(0, 0, 0, 1, 0);
    expect_eq({to_o, pd_o, run_o}, 3'b010, "R7 halt flags and run low");
    // R8 clears ignored while halted
    cur_req = "R8";
    pulse(0, 1, 0, 0, 0); pulse(0, 0, 1, 0, 0); pulse(0, 1, 1, 0, 0);
    expect_eq(int'(pd_o), 1, "R8 clears ignored during halt");
    step(30);
    pulse(0, 0, 0, 0, 1);
    step(100);
    pulse(0, 0, 0, 1, 0);
    step(918);
    expect_eq(int'(run_o), 0, "R8 run still low 1020 cycles after wake");
    step(10);
    expect_eq(int'(run_o), 1, "R8 run high 1024 cycles after wake");

    // R9 expiry during halt sets time-out flag, keeps power-down flag
    cur_req = "R9";
    dual = 1'b0;
    pulse(1, 0, 0, 0, 0);
    sel = 3'd0;
    pulse(0, 0, 0, 1, 0);
    rc0 = req_cnt;
    step(300);
    expect_eq(req_cnt - rc0, 1, "R9 expiry while halted");
    expect_eq({to_o, pd_o}, 2'b11, "R9 time-out and power-down flags during halt");
    pulse(0, 0, 0, 0, 1);
    step(1040);
    expect_eq(int'(run_o), 1, "R8 resumed after second wake");
    step(5);
    finish_run();
  end
endmodule